// File: doc/BRIEF.md
# Battery Status Check Sequencer

This block runs a short self-test on a battery-backed byte memory using nothing but ordinary bus accesses. Such a memory may refuse the first write after power returns when its backup cell has run low. The sequencer detects this by reading a byte, writing its bitwise inverse to the same location, and reading it back. If the inverse did not stick, the write was silently dropped and the battery is flagged as low. In every case the original byte is then written back, so the test location ends up holding what it held before.

System firmware or a power-up controller pulses `start_i` once, with the location to probe on `test_addr_i`. The block drives a single-request memory port: a request with address, write flag and write data, completed by `mem_ready_i` for writes or by `mem_rvalid_i` (with `mem_rdata_i`) for reads. When the restore write has been accepted, `done_o` pulses for one cycle and `battery_low_o` carries the verdict. Repairing data that the low battery may have damaged is left to the system.

Top module: `batt_check_seq`

## Requirements
- R1: While `rst_n` is low and after reset, `mem_req_o`, `done_o` and `battery_low_o` are 0.
- R2: A `start_i` pulse while idle captures `test_addr_i`. The first access that follows is a read (`mem_we_o`=0) of that address.
- R3: The second access is a write of the bitwise inverse of the byte returned by the first read, to the same address.
- R4: The third access is a read of the same address.
- R5: The fourth access writes the byte returned by the first read back to the same address.
- R6: A request holds its address, write flag and write data steady until it completes. A write completes on a cycle with `mem_ready_i`=1, and a read completes on a cycle with `mem_rvalid_i`=1, where `mem_rdata_i` is taken. `mem_req_o` stays high without a gap from the first access through the fourth.
- R7: `battery_low_o` becomes 1 when the second read differs from the inverse of the first read, and 0 otherwise. It changes only in the cycle where `done_o` is 1, and holds that value until the next run completes.
- R8: `done_o` is 1 for exactly one cycle, the cycle after the restore write completes. In that cycle `mem_req_o` is 0.
- R9: A `start_i` pulse while a sequence is running has no effect on the accesses issued or on the address used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a test (taken only when idle) |
| test_addr_i | input | ADDR_W | Location to probe |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_ready_i | input | 1 | Write accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DATA_W | Read data |
| done_o | output | 1 | One-cycle end-of-test pulse |
| battery_low_o | output | 1 | Verdict of the last completed test |

## Verification
The assertions check on every cycle that an unfinished request keeps its address, direction and data, and that the address stays fixed across the four back-to-back accesses. They also check that `done_o` lasts a single cycle, follows an accepted write and drops the request, and that `battery_low_o` moves only with `done_o`. The data relations depend on values captured several accesses earlier, so only the bench scenarios can show them. These are the inverse written second, the original restored last, and the verdict itself. The bench covers them with a memory model that can drop the first write, random handshake latencies, edge addresses, all-zero and all-one bytes, and a start pulse issued mid-run.

// File: rtl/batt_check_pkg.sv
package batt_check_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_READ_ORIG = 3'd1,
        ST_WRITE_INV = 3'd2,
        ST_READ_BACK = 3'd3,
        ST_WRITE_OLD = 3'd4
    } bchk_state_e;

endpackage

// File: rtl/batt_check_bus.sv
// Maps the sequencer state onto the memory request port and reports
// when the access of the current state has completed.
module batt_check_bus
    import batt_check_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  bchk_state_e       state_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] orig_i,
    input  logic              ready_i,
    input  logic              rvalid_i,
    output logic              req_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              step_done_o
);

    always_comb begin
        req_o   = (state_i != ST_IDLE);
        we_o    = (state_i == ST_WRITE_INV) || (state_i == ST_WRITE_OLD);
        addr_o  = addr_i;
        wdata_o = (state_i == ST_WRITE_INV) ? ~orig_i : orig_i;
        if (!req_o) begin
            step_done_o = 1'b0;
        end else if (we_o) begin
            step_done_o = ready_i;
        end else begin
            step_done_o = rvalid_i;
        end
    end

endmodule

// File: rtl/batt_check_verdict.sv
// Flags a read-back that is not the exact inverse of the first read.
module batt_check_verdict #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] first_i,
    input  logic [DATA_W-1:0] second_i,
    output logic              mismatch_o
);

    always_comb begin
        mismatch_o = (second_i != ~first_i);
    end

endmodule

// File: rtl/batt_check_seq.sv
module batt_check_seq
    import batt_check_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] test_addr_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_ready_i,
    input  logic              mem_rvalid_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              done_o,
    output logic              battery_low_o
);

    typedef struct packed {
        bchk_state_e       state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] orig;
        logic              low_pend;
        logic              low;
        logic              done;
    } seq_regs_t;

    seq_regs_t r_q, r_d;
    logic      step_done;
    logic      mismatch;

    batt_check_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .state_i    (r_q.state),
        .addr_i     (r_q.addr),
        .orig_i     (r_q.orig),
        .ready_i    (mem_ready_i),
        .rvalid_i   (mem_rvalid_i),
        .req_o      (mem_req_o),
        .we_o       (mem_we_o),
        .addr_o     (mem_addr_o),
        .wdata_o    (mem_wdata_o),
        .step_done_o(step_done)
    );

    batt_check_verdict #(.DATA_W(DATA_W)) u_verdict (
        .first_i   (r_q.orig),
        .second_i  (mem_rdata_i),
        .mismatch_o(mismatch)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.addr  = test_addr_i;
                    r_d.state = ST_READ_ORIG;
                end
            end
            ST_READ_ORIG: begin
                if (step_done) begin
                    r_d.orig  = mem_rdata_i;
                    r_d.state = ST_WRITE_INV;
                end
            end
            ST_WRITE_INV: begin
                if (step_done) begin
                    r_d.state = ST_READ_BACK;
                end
            end
            ST_READ_BACK: begin
                if (step_done) begin
                    r_d.low_pend = mismatch;
                    r_d.state    = ST_WRITE_OLD;
                end
            end
            ST_WRITE_OLD: begin
                if (step_done) begin
                    r_d.low   = r_q.low_pend;
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, addr: '0, orig: '0,
                     low_pend: 1'b0, low: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o        = r_q.done;
    assign battery_low_o = r_q.low;

endmodule

// File: rtl/batt_check_seq_chk.sv
module batt_check_seq_chk #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input logic              clk_i,
    input logic              rst_n,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [DATA_W-1:0] mem_wdata_o,
    input logic              mem_ready_i,
    input logic              mem_rvalid_i,
    input logic              done_o,
    input logic              battery_low_o
);

    logic finishing;
    assign finishing = mem_we_o ? mem_ready_i : mem_rvalid_i;

    // R6
    hold_until_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        (mem_req_o && !finishing) |=>
        (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

    // R6
    addr_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        (mem_req_o && $past(mem_req_o)) |-> $stable(mem_addr_o));

    // R8
    done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    done_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        done_o |-> (!mem_req_o && $past(mem_req_o && mem_we_o && mem_ready_i)));

    // R7
    low_moves_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        !done_o |-> $stable(battery_low_o));

    // R1
    reset_quiet_chk: assert property (@(posedge clk_i)
        !rst_n |=> (!mem_req_o && !done_o && !battery_low_o));

endmodule

bind batt_check_seq batt_check_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk_i        (clk_i),
    .rst_n        (rst_n),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_ready_i  (mem_ready_i),
    .mem_rvalid_i (mem_rvalid_i),
    .done_o       (done_o),
    .battery_low_o(battery_low_o)
);

// File: tb/batt_check_seq_test.sv
module batt_check_seq_test;

    localparam int AW = 11;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk_i = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] test_addr_i = '0;
    logic          mem_req_o, mem_we_o, done_o, battery_low_o;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_wdata_o;
    logic          mem_ready_i = 1'b0;
    logic          mem_rvalid_i = 1'b0;
    logic [DW-1:0] mem_rdata_i = '0;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    batt_check_seq #(.ADDR_W(AW), .DATA_W(DW)) uut (.*);

    always #10 clk_i = ~clk_i;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory responder with random latency; can drop the next write.
    logic [DW-1:0] mem [DEPTH];
    bit            drop_next_write = 0;
    int            wt = 0;

    always @(negedge clk_i) begin
        if (!rst_n) begin
            mem_ready_i  <= 1'b0;
            mem_rvalid_i <= 1'b0;
            wt = 0;
        end else if (mem_ready_i || mem_rvalid_i) begin
            mem_ready_i  <= 1'b0;
            mem_rvalid_i <= 1'b0;
            mem_rdata_i  <= DW'($urandom);
            wt = $urandom % 4;
        end else if (mem_req_o) begin
            if (wt == 0) begin
                if (mem_we_o) begin
                    if (drop_next_write) drop_next_write = 0;
                    else mem[mem_addr_o] = mem_wdata_o;
                    mem_ready_i <= 1'b1;
                end else begin
                    mem_rdata_i  <= mem[mem_addr_o];
                    mem_rvalid_i <= 1'b1;
                end
            end else begin
                wt--;
            end
        end else begin
            mem_rdata_i <= DW'($urandom);
        end
    end

    // Behavioural reference: step 0 idle, 1..4 the four accesses.
    int            m_step = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_orig = '0;
    bit            m_pend = 0, m_low = 0, m_done = 0;

    always @(posedge clk_i) begin
        cycles++;
        if (!rst_n) begin
            m_step = 0; m_low = 0; m_done = 0; m_pend = 0;
        end else begin
            m_done = 0;
            case (m_step)
                0: if (start_i) begin m_addr = test_addr_i; m_step = 1; end
                1: if (mem_rvalid_i) begin m_orig = mem_rdata_i; m_step = 2; end
                2: if (mem_ready_i) m_step = 3;
                3: if (mem_rvalid_i) begin
                       m_pend = (mem_rdata_i !== ~m_orig);
                       m_step = 4;
                   end
                4: if (mem_ready_i) begin m_step = 0; m_done = 1; m_low = m_pend; end
                default: m_step = 0;
            endcase
        end
    end

    always @(posedge clk_i) begin
        #5;
        if (rst_n) begin
            check(mem_req_o === (m_step != 0), "R6", "req", mem_req_o, m_step != 0);
            check(done_o === m_done, "R8", "done", done_o, m_done);
            check(battery_low_o === m_low, "R7", "battery_low", battery_low_o, m_low);
            if (m_step != 0) begin
                check(mem_addr_o === m_addr, "R2", "addr", mem_addr_o, m_addr);
                check(mem_we_o === (m_step == 2 || m_step == 4), "R4", "we",
                      mem_we_o, (m_step == 2 || m_step == 4));
                if (m_step == 2)
                    check(mem_wdata_o === ~m_orig, "R3", "inverse data", mem_wdata_o, ~m_orig);
                if (m_step == 4)
                    check(mem_wdata_o === m_orig, "R5", "restore data", mem_wdata_o, m_orig);
            end
        end
    end

    task automatic run_test(input logic [AW-1:0] a, input logic [DW-1:0] init,
                            input bit drop, input bit exp_low, input bit poke);
        bit seen = 0;
        mem[a] = init;
        drop_next_write = drop;
        @(negedge clk_i);
        test_addr_i = a;
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        test_addr_i = ~a;
        for (int i = 0; i < 200; i++) begin
            if (poke && i == 3) start_i = 1'b1;  // R9: mid-run start
            if (poke && i == 4) start_i = 1'b0;
            @(negedge clk_i);
            if (done_o) begin seen = 1; break; end
        end
        start_i = 1'b0;
        check(seen, "R8", "done seen", seen, 1);
        check(battery_low_o === exp_low, "R7", "verdict", battery_low_o, exp_low);
        check(mem[a] === init, "R5", "byte restored", mem[a], init);
        @(negedge clk_i);
        check(!done_o && !mem_req_o, "R9", "idle after done (no restart)",
              {done_o, mem_req_o}, 0);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = DW'(i * 37 + 5);
        repeat (3) @(negedge clk_i);
        check(!mem_req_o && !done_o && !battery_low_o, "R1", "reset outputs",
              {mem_req_o, done_o, battery_low_o}, 0);
        rst_n = 1'b1;
        @(negedge clk_i);
        check(!mem_req_o && !done_o && !battery_low_o, "R1", "after reset",
              {mem_req_o, done_o, battery_low_o}, 0);
        run_test(11'h155, 8'hA5, 0, 0, 0);
        run_test(11'h000, 8'h00, 1, 1, 0);
        run_test(11'h7FF, 8'hFF, 0, 0, 0);
        run_test(11'h7FF, 8'h3C, 1, 1, 1);
        run_test(11'h2A0, 8'h81, 0, 0, 1);
        check(mem[11'h7FF ^ 11'h7FF] === 8'h00, "R9", "other address untouched",
              mem[0], 8'h00);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        checks++;
        failures++;
        $display("FAIL R8 watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule